// File: doc/BRIEF.md
# Clamped Duty Accumulator and PWM Generator

This block holds the PWM duty value for a motor drive and turns it into a pulse train. Each cycle, an outer PI regulator may present a signed correction together with a strobe. The block adds that correction to a stored duty count or subtracts it from that count, clamps the result to a safe band, and keeps the result. The starting value is low enough to give the motor a gentle start.

A free-running period counter is compared against a shadow copy of the duty count to form the PWM waveform. The shadow copy picks up the newest duty count only when the period restarts, so a correction that arrives mid-period never cuts a pulse short or stretches it. A stop input blanks the output at once and leaves the stored duty untouched, so running resumes from the same point.

Top module: `duty_pwm_top`

## Requirements
- R1: After reset, the duty count (`duty_o`) is 1000 and the period counter starts at 0. The PWM output is therefore high at the start of the first period.
- R2: A correction with bit 13 clear is positive. On a strobed cycle its 13-bit magnitude (bits 12:0) is added to the duty count, and the new value is visible on `duty_o` one clock later.
- R3: A correction with bit 13 set is negative. On a strobed cycle its magnitude is subtracted. A negative zero leaves the duty count unchanged.
- R4: The duty count never exceeds 2889 (96.3%). A sum above that limit stores 2889.
- R5: The duty count never falls below 690 (23%). A difference below that limit stores 690, even when the magnitude is larger than the current count.
- R6: When the strobe is low, `corr_i` has no effect on the duty count.
- R7: The period counter advances on every clock from 0 to 2999 and then returns to 0.
- R8: While not stopped, the PWM output is high when the counter is less than or equal to the active duty and low when it is greater. A full period therefore has exactly duty+1 high cycles.
- R9: A changed duty count drives the comparison only from the next counter wrap onwards. The rest of the current period uses the old value.
- R10: While `stop_i` is high, the PWM output is low and the duty count keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| corr_valid_i | input | 1 | Strobe: apply `corr_i` this cycle |
| corr_i | input | 14 | Sign-magnitude correction; bit 13 is the sign, bits 12:0 are the magnitude |
| stop_i | input | 1 | Forces the PWM output low |
| duty_o | output | 12 | Stored (accumulated) duty count |
| pwm_o | output | 1 | PWM output |

## Verification
The bench pushes sums and differences past both clamp limits with full-scale magnitudes. A design that works at the duty width would wrap to a small or huge duty instead of saturating. Negative zero and unstrobed corrections are checked, because a design that misreads the sign or ignores the strobe would move the duty count. The comparison is probed exactly at the counter values equal to the duty and one above it, and the high cycles are counted over a whole period; an off-by-one in the compare shows up as a wrong count. A mid-period correction must not change the output before the wrap, which catches a design that compares against the live register. The bench also checks that a stop blanks the output and leaves the duty count intact.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int CORR_W = 14;
  localparam int MAG_W  = CORR_W - 1;

  typedef struct packed {
    logic             neg;
    logic [MAG_W-1:0] mag;
  } corr_t;
endpackage

// File: rtl/dp_accum.sv
module dp_accum
  import dp_pkg::*;
#(
  parameter int DUTY_W    = 12,
  parameter int DUTY_MIN  = 690,
  parameter int DUTY_MAX  = 2889,
  parameter int DUTY_INIT = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  corr_t             corr_i,
  output logic [DUTY_W-1:0] duty_o
);
  // Wide enough for duty + magnitude or duty - magnitude with sign
  localparam int SUM_W = ((DUTY_W > MAG_W) ? DUTY_W : MAG_W) + 2;
  localparam logic signed [SUM_W-1:0] MIN_S = SUM_W'(DUTY_MIN);
  localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'(DUTY_MAX);

  logic [DUTY_W-1:0]       duty_q, duty_d;
  logic signed [SUM_W-1:0] duty_ext, mag_ext, sum_w;

  assign duty_ext = $signed({{(SUM_W-DUTY_W){1'b0}}, duty_q});
  assign mag_ext  = $signed({{(SUM_W-MAG_W){1'b0}}, corr_i.mag});
  assign sum_w    = corr_i.neg ? (duty_ext - mag_ext) : (duty_ext + mag_ext);

  always_comb begin
    duty_d = duty_q;
    if (valid_i) begin
      if (sum_w > MAX_S)      duty_d = DUTY_W'(DUTY_MAX);
      else if (sum_w < MIN_S) duty_d = DUTY_W'(DUTY_MIN);
      else                    duty_d = sum_w[DUTY_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) duty_q <= DUTY_W'(DUTY_INIT);
    else         duty_q <= duty_d;
  end

  assign duty_o = duty_q;

  a_r4_r5_in_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_q >= DUTY_W'(DUTY_MIN)) && (duty_q <= DUTY_W'(DUTY_MAX)));

  a_r6_hold_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(duty_q));

  a_r2_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !corr_i.neg && (duty_ext + mag_ext <= MAX_S))
    |=> (duty_q == $past(duty_q) + DUTY_W'($past(corr_i.mag))));

  a_r3_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && corr_i.neg && (duty_ext - mag_ext >= MIN_S))
    |=> (duty_q == $past(duty_q) - DUTY_W'($past(corr_i.mag))));
endmodule

// File: rtl/dp_counter.sv
module dp_counter #(
  parameter int PERIOD = 3000,
  parameter int CNT_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LAST);

  a_r7_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  a_r7_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> (cnt_q == '0));

  a_r7_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/dp_compare.sv
module dp_compare #(
  parameter int DUTY_W    = 12,
  parameter int DUTY_INIT = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [DUTY_W-1:0] cnt_i,
  input  logic              last_i,
  input  logic              stop_i,
  output logic              pwm_o
);
  // Shadow copy: loaded at the last count so it is live when counter is 0
  logic [DUTY_W-1:0] active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_q <= DUTY_W'(DUTY_INIT);
    else if (last_i) active_q <= duty_i;
  end

  assign pwm_o = !stop_i && (cnt_i <= active_q);

  a_r9_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> $stable(active_q));

  a_r9_shadow_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i |=> (active_q == $past(duty_i)));
endmodule

// File: rtl/duty_pwm_top.sv
module duty_pwm_top
  import dp_pkg::*;
#(
  parameter int PERIOD    = 3000,
  parameter int DUTY_MIN  = 690,
  parameter int DUTY_MAX  = 2889,
  parameter int DUTY_INIT = 1000,
  localparam int CNT_W    = $clog2(PERIOD)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              corr_valid_i,
  input  logic [CORR_W-1:0] corr_i,
  input  logic              stop_i,
  output logic [CNT_W-1:0]  duty_o,
  output logic              pwm_o
);
  logic [CNT_W-1:0] cnt_w;
  logic             last_w;
  corr_t            corr_w;

  assign corr_w = corr_t'(corr_i);

  dp_accum #(
    .DUTY_W   (CNT_W),
    .DUTY_MIN (DUTY_MIN),
    .DUTY_MAX (DUTY_MAX),
    .DUTY_INIT(DUTY_INIT)
  ) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(corr_valid_i),
    .corr_i (corr_w),
    .duty_o (duty_o)
  );

  dp_counter #(
    .PERIOD(PERIOD),
    .CNT_W (CNT_W)
  ) u_counter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt_w),
    .last_o(last_w)
  );

  dp_compare #(
    .DUTY_W   (CNT_W),
    .DUTY_INIT(DUTY_INIT)
  ) u_compare (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .duty_i(duty_o),
    .cnt_i (cnt_w),
    .last_i(last_w),
    .stop_i(stop_i),
    .pwm_o (pwm_o)
  );

  a_r10_stop_blanks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> !pwm_o);

  a_r1_high_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_w == '0 && !stop_i) |-> pwm_o);
endmodule

// File: tb/duty_pwm_top_tb_top.sv
module duty_pwm_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PERIOD     = 3000;
  localparam int N_TAB      = 12;

  // Sign-magnitude corrections: bit 13 = negative, bits 12:0 = magnitude
  localparam logic [13:0] CORR_TAB [N_TAB] = '{
    14'h0000 | 14'd500,    // +500  -> 1500 (R2)
    14'h2000 | 14'd200,    // -200  -> 1300 (R3)
    14'h0000 | 14'd8191,   // +8191 -> 2889 (R4)
    14'h2000 | 14'd0,      // -0    -> 2889 (R3)
    14'h2000 | 14'd8191,   // -8191 -> 690  (R5)
    14'h2000 | 14'd1,      // -1    -> 690  (R5)
    14'h0000 | 14'd10,     // +10   -> 700  (R2)
    14'h2000 | 14'd0,      // -0    -> 700  (R3)
    14'h0000 | 14'd2000,   // +2000 -> 2700 (R2)
    14'h0000 | 14'd189,    // +189  -> 2889 (R4 exact)
    14'h2000 | 14'd2199,   // -2199 -> 690  (R5 exact)
    14'h0000 | 14'd2500    // +2500 -> 2889 (R4)
  };
  localparam int EXP_TAB [N_TAB] = '{
    1500, 1300, 2889, 2889, 690, 690, 700, 700, 2700, 2889, 690, 2889
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        corr_valid = 1'b0;
  logic [13:0] corr = '0;
  logic        stop = 1'b0;
  logic [11:0] duty;
  logic        pwm;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  duty_pwm_top dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .corr_valid_i(corr_valid),
    .corr_i      (corr),
    .stop_i      (stop),
    .duty_o      (duty),
    .pwm_o       (pwm)
  );

  // Mirrors elapsed cycles only; counter position = cyc % PERIOD
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;
  end

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    corr_valid = 1'b0;
    stop = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic apply(logic [13:0] c);
    @(negedge clk);
    corr = c;
    corr_valid = 1'b1;
    @(negedge clk);
    corr_valid = 1'b0;
  endtask

  task automatic wait_cnt(int t);
    do begin
      @(posedge clk);
      #1;
    end while ((cyc % PERIOD) != t);
  endtask

  task automatic count_highs(output int highs);
    highs = 0;
    for (int i = 0; i < PERIOD; i++) begin
      @(posedge clk);
      #1;
      if (pwm) highs++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int highs;
    do_reset();
    #1;
    // R1: reset state
    check("R1 duty after reset", int'(duty), 1000);
    check("R1 pwm at counter 0", int'(pwm), 1);

    // Vector table walk
    for (int k = 0; k < N_TAB; k++) begin
      apply(CORR_TAB[k]);
      check($sformatf("R2/R3/R4/R5 table entry %0d", k), int'(duty), EXP_TAB[k]);
    end

    // Directed: fresh start
    do_reset();

    // R6: unstrobed corrections do nothing
    @(negedge clk);
    corr = 14'd500;
    repeat (4) @(negedge clk);
    corr = 14'h2000 | 14'd400;
    repeat (4) @(negedge clk);
    check("R6 unstrobed ignored", int'(duty), 1000);

    // R8: full-period high count with duty 1000
    wait_cnt(0);
    count_highs(highs);
    check("R8 highs per period at 1000", highs, 1001);

    // R9: mid-period change waits for wrap
    wait_cnt(1500);
    apply(14'd1000);
    check("R2 mid-period add", int'(duty), 2000);
    wait_cnt(1600);
    check("R9 old duty until wrap", int'(pwm), 0);
    wait_cnt(1600);
    check("R9 new duty after wrap", int'(pwm), 1);

    // R8: compare boundary
    wait_cnt(2000);
    check("R8 high at count == duty", int'(pwm), 1);
    wait_cnt(2001);
    check("R8 low at count == duty+1", int'(pwm), 0);
    wait_cnt(2999);
    check("R7 low at last count", int'(pwm), 0);
    wait_cnt(0);
    check("R7 wrap to 0 gives high", int'(pwm), 1);
    count_highs(highs);
    check("R8 highs per period at 2000", highs, 2001);

    // R10: stop blanks output and keeps duty
    wait_cnt(100);
    @(negedge clk);
    stop = 1'b1;
    wait_cnt(200);
    check("R10 pwm low while stopped", int'(pwm), 0);
    check("R10 duty kept while stopped", int'(duty), 2000);
    @(negedge clk);
    stop = 1'b0;
    wait_cnt(300);
    check("R10 pwm resumes after stop", int'(pwm), 1);
    check("R10 duty unchanged after stop", int'(duty), 2000);

    finish_run();
  end
endmodule